// File: doc/BRIEF.md
# Perturbative Parameter Update Controller

This block runs one learning iteration of a two-sided random-direction perturbation scheme over a bank of digitally held parameters. The bank is the weight matrix of a small fully connected recurrent network plus one threshold per neuron. With the default six neurons it holds 36 weights and 6 thresholds. After a start pulse, the block presents the parameters shifted by a signed perturbation. It then presents them shifted the opposite way, and it samples an externally computed error value at the end of each of these two phases. It halves the difference of the two samples to form a signed perturbed error, and scales the magnitude of that error by a learning rate to give one shared step.

On a single update strobe, every parameter takes that step. The direction of each parameter's step is the exclusive-or of the perturbed-error sign and the parameter's own perturbation bit. The perturbed values leave the block on a flat output bus. The error measurement and the network being trained are outside the block.

The perturbation polarity of each parameter comes from one input bit per parameter, which the block latches when the iteration starts. Parameters are signed and saturate at both the perturbed output and the stored value, so a large amplitude or step never wraps. On reset, each diagonal weight holds a programmable positive value and all other parameters hold zero.

Top module: `pert_update_ctrl`

## Requirements
- R1: After reset, busy_o, upd_o and done_o are 0, phase_o is 0 and every parameter reads its initial value. Diagonal weight (r,c) with r==c sits at index r*NNEUR+c and reads INIT_DIAG. All other weights and all thresholds (indices NNEUR*NNEUR and up) read 0.
- R2: A start_i seen while idle begins an iteration. From the next cycle, busy_o stays 1 through the update cycle. done_o is a one-cycle pulse in the cycle after upd_o, and in that cycle busy_o is already 0.
- R3: The first phase (phase_o=1) lasts PH_CYC cycles. During it, parameter i reads p+a when its latched bit is 0 and p-a when the bit is 1. Here a is amp_i, taken as unsigned.
- R4: The second phase (phase_o=2) follows at once and lasts PH_CYC cycles, with the opposite offset: p-a for bit 0 and p+a for bit 1.
- R5: err_i is sampled in the last cycle of each phase. The perturbed error is (E1-E2)/2, with its magnitude truncated to an integer, where E1 is the first-phase sample and E2 is the second-phase sample.
- R6: The shared step is floor(|perturbed error| * lrate_i / 2^LR_FRAC), clipped to the largest positive parameter value.
- R7: A parameter increments when (E1<E2) XOR its bit is 1 and decrements otherwise. A step of zero leaves every parameter unchanged.
- R8: upd_o is a one-cycle pulse two cycles after the second phase ends. Stored parameters change only on it. Outside the two phases, param_o shows the stored values.
- R9: Perturbation bits are latched when start is accepted. Changes on pert_bits_i during an iteration have no effect on that iteration.
- R10: start_i while busy_o is 1 is ignored and starts no further iteration.
- R11: Perturbed outputs saturate at the signed limits of PW bits instead of wrapping.
- R12: Updated parameters saturate at the signed limits of PW bits instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an iteration when idle |
| err_i | input | EW | Unsigned error measurement |
| pert_bits_i | input | NNEUR*NNEUR+NNEUR | Per-parameter perturbation polarity, 1 = negative |
| amp_i | input | PW | Unsigned perturbation amplitude |
| lrate_i | input | LRW | Learning rate, LR_FRAC fraction bits |
| param_o | output | (NNEUR*NNEUR+NNEUR)*PW | Perturbed parameter values, index i at bits [i*PW +: PW] |
| phase_o | output | 2 | 0 nominal, 1 first perturbed phase, 2 second perturbed phase |
| busy_o | output | 1 | Iteration in progress |
| upd_o | output | 1 | Update strobe |
| done_o | output | 1 | Iteration complete pulse |

## Verification
The bench targets the sign conventions. A swapped exclusive-or or a reversed difference would move every parameter the wrong way, and a zero perturbed error that still moved parameters would show up in the equal-error case. An odd error difference and a small learning rate test the truncation: rounding up would give a nonzero step where zero is expected. Large amplitudes and repeated maximal steps push both the perturbed outputs and the stored values against their limits, where wrapping arithmetic would flip the sign. Perturbation bits that change in the middle of an iteration, and a start that arrives while busy, expose a design that reads the bits live or restarts, because the second phase or the idle cycle after done would differ.

// File: rtl/pu_pkg.sv
package pu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PLUS   = 3'd1,
    ST_MINUS  = 3'd2,
    ST_CALC   = 3'd3,
    ST_COMMIT = 3'd4
  } pu_state_e;

  typedef enum logic [1:0] {
    PH_NOM   = 2'd0,
    PH_PLUS  = 2'd1,
    PH_MINUS = 2'd2
  } pu_phase_e;
endpackage

// File: rtl/pu_seq.sv
module pu_seq
  import pu_pkg::*;
#(
  parameter int EW     = 16,
  parameter int PH_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [EW-1:0] err_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          upd_o,
  output logic          load_o,
  output logic          calc_o,
  output pu_phase_e     phase_o,
  output logic [EW-1:0] err_p_o,
  output logic [EW-1:0] err_m_o
);
  localparam int CW = (PH_CYC < 2) ? 1 : $clog2(PH_CYC);

  pu_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [EW-1:0] ep_q, ep_d, em_q, em_d;
  logic          done_q, done_d;
  logic          last;

  assign last = (cnt_q == CW'(PH_CYC - 1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ep_d    = ep_q;
    em_d    = em_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_PLUS;
          cnt_d   = '0;
        end
      end
      ST_PLUS: begin
        if (last) begin
          ep_d    = err_i;
          cnt_d   = '0;
          state_d = ST_MINUS;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_MINUS: begin
        if (last) begin
          em_d    = err_i;
          cnt_d   = '0;
          state_d = ST_CALC;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_CALC:   state_d = ST_COMMIT;
      ST_COMMIT: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ep_q    <= '0;
      em_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ep_q    <= ep_d;
      em_q    <= em_d;
      done_q  <= done_d;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign upd_o   = (state_q == ST_COMMIT);
  assign calc_o  = (state_q == ST_CALC);
  assign load_o  = (state_q == ST_IDLE) && start_i;
  assign phase_o = (state_q == ST_PLUS)  ? PH_PLUS :
                   (state_q == ST_MINUS) ? PH_MINUS : PH_NOM;
  assign err_p_o = ep_q;
  assign err_m_o = em_q;
endmodule

// File: rtl/pu_step.sv
module pu_step #(
  parameter int EW      = 16,
  parameter int PW      = 16,
  parameter int LRW     = 8,
  parameter int LR_FRAC = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic [EW-1:0]  err_p_i,
  input  logic [EW-1:0]  err_m_i,
  input  logic [LRW-1:0] lrate_i,
  output logic [PW-1:0]  step_o,
  output logic           neg_o
);
  localparam int DW  = EW + 1;
  localparam int PRW = EW + LRW;
  localparam logic [PRW-1:0] STEP_MAX = PRW'((64'd1 << (PW - 1)) - 64'd1);

  logic [DW-1:0]  diff, absd;
  logic [EW-1:0]  mag;
  logic [PRW-1:0] prod, scaled;
  logic [PW-1:0]  step_q, step_d;
  logic           neg_q, neg_d;

  always_comb begin
    diff   = {1'b0, err_p_i} - {1'b0, err_m_i};
    neg_d  = diff[DW-1];
    absd   = neg_d ? (~diff + DW'(1)) : diff;
    mag    = EW'(absd >> 1);
    prod   = PRW'(mag) * PRW'(lrate_i);
    scaled = prod >> LR_FRAC;
    step_d = (scaled > STEP_MAX) ? STEP_MAX[PW-1:0] : scaled[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      neg_q  <= 1'b0;
    end else if (en_i) begin
      step_q <= step_d;
      neg_q  <= neg_d;
    end
  end

  assign step_o = step_q;
  assign neg_o  = neg_q;
endmodule

// File: rtl/pu_cell.sv
module pu_cell
  import pu_pkg::*;
#(
  parameter int                     PW   = 16,
  parameter logic signed [PW-1:0]   INIT = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic                 bit_i,
  input  pu_phase_e            phase_i,
  input  logic [PW-1:0]        amp_i,
  input  logic                 upd_i,
  input  logic [PW-1:0]        step_i,
  input  logic                 neg_i,
  output logic signed [PW-1:0] val_o
);
  localparam int XW = PW + 2;
  localparam logic signed [XW-1:0] HI = XW'((64'd1 << (PW - 1)) - 64'd1);
  localparam logic signed [XW-1:0] LO = -HI - XW'(1);

  logic signed [PW-1:0] p_q, p_d;
  logic                 bit_q, bit_d;
  logic signed [XW-1:0] ext_p, ext_a, ext_s, pert, nxt;
  logic                 sub_amp, inc;

  function automatic logic signed [PW-1:0] clip(input logic signed [XW-1:0] x);
    if (x > HI)      clip = HI[PW-1:0];
    else if (x < LO) clip = LO[PW-1:0];
    else             clip = x[PW-1:0];
  endfunction

  always_comb begin
    ext_p   = {{2{p_q[PW-1]}}, p_q};
    ext_a   = {2'b00, amp_i};
    ext_s   = {2'b00, step_i};
    sub_amp = (phase_i == PH_PLUS) ? bit_q : ~bit_q;
    pert    = sub_amp ? (ext_p - ext_a) : (ext_p + ext_a);
    inc     = neg_i ^ bit_q;
    nxt     = inc ? (ext_p + ext_s) : (ext_p - ext_s);
    p_d     = upd_i ? clip(nxt) : p_q;
    bit_d   = load_i ? bit_i : bit_q;
    val_o   = (phase_i == PH_NOM) ? p_q : clip(pert);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q   <= INIT;
      bit_q <= 1'b0;
    end else begin
      p_q   <= p_d;
      bit_q <= bit_d;
    end
  end
endmodule

// File: rtl/pert_update_ctrl.sv
module pert_update_ctrl
  import pu_pkg::*;
#(
  parameter int NNEUR     = 6,
  parameter int PW        = 16,
  parameter int EW        = 16,
  parameter int LRW       = 8,
  parameter int LR_FRAC   = 4,
  parameter int PH_CYC    = 4,
  parameter int INIT_DIAG = 256
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start_i,
  input  logic [EW-1:0]                       err_i,
  input  logic [NNEUR*NNEUR+NNEUR-1:0]        pert_bits_i,
  input  logic [PW-1:0]                       amp_i,
  input  logic [LRW-1:0]                      lrate_i,
  output logic [(NNEUR*NNEUR+NNEUR)*PW-1:0]   param_o,
  output logic [1:0]                          phase_o,
  output logic                                busy_o,
  output logic                                upd_o,
  output logic                                done_o
);
  localparam int NW   = NNEUR * NNEUR;
  localparam int NPAR = NW + NNEUR;

  pu_phase_e     phase;
  logic          load, calc;
  logic [EW-1:0] err_p, err_m;
  logic [PW-1:0] step;
  logic          neg;

  pu_seq #(.EW(EW), .PH_CYC(PH_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .err_i   (err_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .upd_o   (upd_o),
    .load_o  (load),
    .calc_o  (calc),
    .phase_o (phase),
    .err_p_o (err_p),
    .err_m_o (err_m)
  );

  pu_step #(.EW(EW), .PW(PW), .LRW(LRW), .LR_FRAC(LR_FRAC)) u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (calc),
    .err_p_i (err_p),
    .err_m_i (err_m),
    .lrate_i (lrate_i),
    .step_o  (step),
    .neg_o   (neg)
  );

  for (genvar gi = 0; gi < NPAR; gi++) begin : g_cell
    localparam bit IS_DIAG = (gi < NW) && ((gi % NNEUR) == (gi / NNEUR));
    localparam logic signed [PW-1:0] INIT_V = IS_DIAG ? PW'(INIT_DIAG) : '0;
    logic signed [PW-1:0] val;

    pu_cell #(.PW(PW), .INIT(INIT_V)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .bit_i   (pert_bits_i[gi]),
      .phase_i (phase),
      .amp_i   (amp_i),
      .upd_i   (upd_o),
      .step_i  (step),
      .neg_i   (neg),
      .val_o   (val)
    );
    assign param_o[gi*PW +: PW] = val;
  end

  assign phase_o = phase;
endmodule

// File: rtl/pu_chk.sv
module pu_chk #(
  parameter int PARW = 672
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [PARW-1:0] param_o,
  input logic [1:0]      phase_o,
  input logic            busy_o,
  input logic            upd_o,
  input logic            done_o
);
  // R8
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);

  // R2
  done_after_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> (done_o && !busy_o));

  // R2
  phase_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != 2'd0) |-> busy_o);

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (phase_o == 2'd1));

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !upd_o) |=> busy_o);

  // R8
  param_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd0 && $past(phase_o) == 2'd0 && !$past(upd_o)) |-> $stable(param_o));

  // R3
  phase_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o != 2'd3);
endmodule

bind pert_update_ctrl pu_chk #(.PARW((NNEUR*NNEUR+NNEUR)*PW)) u_pu_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .param_o (param_o),
  .phase_o (phase_o),
  .busy_o  (busy_o),
  .upd_o   (upd_o),
  .done_o  (done_o)
);

// File: tb/tb_pert_update_ctrl.sv
module tb_pert_update_ctrl;
  localparam int CLK_P  = 10;
  localparam int NN     = 6;
  localparam int NP     = NN*NN + NN;
  localparam int PW     = 16;
  localparam int PH     = 4;
  localparam int IDIAG  = 256;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [15:0]       err;
  logic [NP-1:0]     bits;
  logic [PW-1:0]     amp;
  logic [7:0]        lrate;
  logic [NP*PW-1:0]  param_o;
  logic [1:0]        phase_o;
  logic              busy_o, upd_o, done_o;

  int checks = 0;
  int fails  = 0;
  int mp [NP];

  always #(CLK_P/2) clk = ~clk;

  pert_update_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .err_i(err),
    .pert_bits_i(bits), .amp_i(amp), .lrate_i(lrate),
    .param_o(param_o), .phase_o(phase_o), .busy_o(busy_o),
    .upd_o(upd_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clampv(input int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic int pget(input int i);
    return int'($signed(param_o[i*PW +: PW]));
  endfunction

  // mode 0 nominal, 1 first phase, 2 second phase
  task automatic chk_bank(input int mode, input logic [NP-1:0] b, input int a, input string req, input string what);
    int bad = -1; int act = 0; int exp = 0;
    for (int i = 0; i < NP; i++) begin
      int off = b[i] ? -a : a;
      int e = (mode == 0) ? mp[i] : (mode == 1) ? clampv(mp[i] + off) : clampv(mp[i] - off);
      if (bad < 0 && pget(i) != e) begin bad = i; act = pget(i); exp = e; end
    end
    chk(bad < 0, req, what, act, exp);
  endtask

  function automatic logic [NP-1:0] pattern(input int k);
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++) r[i] = ((i * 7 + k) % 3) == 0;
    return r;
  endfunction

  task automatic iterate(input int ep, input int em, input int lr, input int a,
                         input logic [NP-1:0] b, input bit disturb, input string tag);
    int np = 0; int nm = 0; int diff; int mag; int stp; bit neg;
    @(negedge clk);
    bits = b; amp = PW'(a); lrate = 8'(lr); err = 16'(ep); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy_o == 1'b1, "R2", {tag, " busy after start"}, busy_o, 1);
    while (phase_o == 2'd1 && np < 50) begin
      np++;
      if (np == 1) chk_bank(1, b, a, a > 32767 ? "R11" : "R3", {tag, " first phase values"});
      if (disturb) bits = ~b;
      @(negedge clk);
    end
    chk(np == PH, "R3", {tag, " first phase length"}, np, PH);
    err = 16'(em);
    while (phase_o == 2'd2 && nm < 50) begin
      nm++;
      if (nm == 1) chk_bank(2, b, a, disturb ? "R9" : "R4", {tag, " second phase values"});
      if (disturb && nm == 2) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(nm == PH, "R4", {tag, " second phase length"}, nm, PH);
    chk(busy_o && !upd_o && phase_o == 2'd0, "R8", {tag, " calc cycle no strobe"}, upd_o, 0);
    chk_bank(0, b, a, "R8", {tag, " nominal before update"});
    @(negedge clk);
    chk(upd_o == 1'b1 && busy_o, "R8", {tag, " update strobe"}, upd_o, 1);
    chk_bank(0, b, a, "R8", {tag, " unchanged during strobe"});
    diff = ep - em;
    neg  = diff < 0;
    mag  = (neg ? -diff : diff) >> 1;
    stp  = (mag * lr) >> 4;
    if (stp > 32767) stp = 32767;
    for (int i = 0; i < NP; i++) begin
      bit inc = neg ^ b[i];
      mp[i] = clampv(inc ? mp[i] + stp : mp[i] - stp);
    end
    @(negedge clk);
    chk(done_o && !busy_o && !upd_o, "R2", {tag, " done pulse"}, done_o, 1);
    chk_bank(0, b, a, "R7", {tag, " updated bank (R5 R6 R12)"});
    @(negedge clk);
    chk(!done_o && !busy_o, "R10", {tag, " idle after done"}, busy_o, 0);
  endtask

  task automatic t_reset;
    for (int i = 0; i < NP; i++) mp[i] = (i < NN*NN && (i % NN) == (i / NN)) ? IDIAG : 0;
    chk(!busy_o && !upd_o && !done_o && phase_o == 2'd0, "R1", "reset flags", busy_o, 0);
    chk_bank(0, '0, 0, "R1", "reset bank");
  endtask

  task automatic t_basic;     iterate(1000, 600, 16, 50, pattern(0), 1'b0, "R7 positive"); endtask
  task automatic t_negative;  iterate(300, 900, 40, 120, pattern(1), 1'b0, "R5 negative"); endtask
  task automatic t_zero;      iterate(500, 500, 200, 10, pattern(2), 1'b0, "R7 zero"); endtask
  task automatic t_odd;       iterate(7, 0, 16, 3, pattern(0), 1'b0, "R6 odd"); endtask
  task automatic t_trunc;     iterate(7, 0, 1, 3, pattern(1), 1'b0, "R6 trunc"); endtask
  task automatic t_disturb;   iterate(2000, 100, 8, 77, pattern(2), 1'b1, "R9 R10 disturb"); endtask
  task automatic t_sat_pert;  iterate(100, 200, 16, 40000, pattern(0), 1'b0, "R11 amp"); endtask
  task automatic t_sat_upd;
    iterate(65535, 0, 255, 5, pattern(1), 1'b0, "R12 max a");
    iterate(0, 65535, 255, 5, pattern(1), 1'b0, "R12 max b");
    iterate(65535, 0, 255, 5, pattern(1), 1'b0, "R12 max c");
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; err = '0; bits = '0; amp = '0; lrate = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_negative();
    t_zero();
    t_odd();
    t_trunc();
    t_disturb();
    t_sat_pert();
    t_sat_upd();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule